// File: doc/BRIEF.md
# Digital third-order cascaded noise-shaping modulator

This block turns a stream of signed multi-bit samples into a short signed code whose average follows the input. The error left by the coarse quantizers is pushed toward high frequencies by a third-order difference. Three first-order accumulator loops are chained. Each loop integrates its input and quantizes the accumulator to a single level of plus or minus full scale. The loop then hands its negated quantization error to the next loop. A digital network delays and differentiates the outputs of the later loops and adds them to the first loop's output. This cancels the errors of the first two loops. Only the third loop's error remains, shaped by (1 - z^-1)^3.

Full scale is FS = 2^(DW-1), and the input word covers [-FS, FS-1]. The state advances once per accepted sample, and every accepted sample yields exactly one output code. Each loop is only first order, so the cascade cannot become unstable for any input word. A typical use is to drive a small multi-level DAC or a fractional divider, with a low-pass filter after it.

Top module: `mash111_mod`

## Requirements
- R1: After a synchronous reset, while no sample has been accepted, `dout` is 0 and `dout_vld` is 0.
- R2: A sample is accepted on a rising clock edge when `din_vld` is 1. `dout_vld` is 1 in the cycle that follows that edge and 0 in all other cycles.
- R3: The output codes for the first two samples accepted after reset are 0.
- R4: Each loop has a signed accumulator `a` that is cleared by reset. Its quantizer bit is 1 when `a` >= 0, which represents +FS, and 0 otherwise, which represents -FS. On each accepted sample the accumulator becomes `a + u - v`, where `u` is the loop's input and `v` is its quantizer level.
- R5: The first loop's input is `din`, sign-extended. The second loop's input is `a1 - v1`, and the third loop's input is `a2 - v2`. Each is the negated quantization error of the previous loop, taken before the update.
- R6: From the third accepted sample onward, `dout` is computed from the quantizer levels in units of FS, where p[n] is the value before the n-th update: `dout = p1[n-2] + p2[n-1] - p2[n-2] + p3[n] - 2*p3[n-1] + p3[n-2]`.
- R7: From the third accepted sample onward, `dout` is odd and lies in -7..+7. It is a 4-bit two's-complement value.
- R8: For any input word, every accumulator stays within [-2^DW, 2^DW), so no overflow occurs.
- R9: While `din_vld` is 0, `din` is ignored. The accumulators, the history and `dout` keep their values.
- R10: For a DC input x, the sum of N output codes, multiplied by FS, differs from N*x by at most 16*FS. The long-run mean therefore equals x/FS.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| din_vld | input | 1 | Input sample strobe |
| din | input | DW | Signed input sample, full scale 2^(DW-1) |
| dout_vld | output | 1 | Output code strobe |
| dout | output | 4 | Signed noise-shaped output code |

## Verification
The assertions take for granted two things. First, `din` holds a two's-complement word of DW bits; the accumulator bound in R8 is derived from that range. Second, `rst` is held for at least one edge before samples arrive. The stimulus uses only words within that range, including both extremes -FS and FS-1. It also applies reset only while the block is idle, so the history masking of R3 is exercised fresh in each run. Gaps in `din_vld` carry deliberately changing `din` values, so that R9 is visible at the outputs.

// File: rtl/mash111_mod.sv
module mash111_mod #(
  parameter int DW = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 din_vld,
  input  logic signed [DW-1:0] din,
  output logic                 dout_vld,
  output logic signed [3:0]    dout
);
  localparam int AW = DW + 2;
  localparam int OW = 4;
  localparam logic signed [AW-1:0] FS  = AW'(1) << (DW - 1);
  localparam logic signed [AW-1:0] LIM = AW'(1) << DW;

  logic signed [AW-1:0] acc1, acc2, acc3;
  logic signed [AW-1:0] lv1, lv2, lv3;
  logic signed [AW-1:0] u2, u3;
  logic signed [AW-1:0] nx1, nx2, nx3;
  logic q1, q2, q3;
  logic q1d1, q1d2, q2d1, q2d2, q3d1, q3d2;
  logic [1:0] fill;
  logic signed [OW-1:0] mix;

  function automatic logic signed [OW-1:0] lvl(input logic b);
    return b ? OW'(1) : -OW'(1);
  endfunction

  assign q1  = ~acc1[AW-1];
  assign q2  = ~acc2[AW-1];
  assign q3  = ~acc3[AW-1];
  assign lv1 = q1 ? FS : -FS;
  assign lv2 = q2 ? FS : -FS;
  assign lv3 = q3 ? FS : -FS;

  assign u2  = acc1 - lv1;
  assign u3  = acc2 - lv2;
  assign nx1 = acc1 + AW'(din) - lv1;
  assign nx2 = acc2 + u2 - lv2;
  assign nx3 = acc3 + u3 - lv3;

  assign mix = lvl(q1d2) + lvl(q2d1) - lvl(q2d2)
             + lvl(q3) - (lvl(q3d1) <<< 1) + lvl(q3d2);

  always_ff @(posedge clk) begin
    if (rst) begin
      acc1 <= '0; acc2 <= '0; acc3 <= '0;
      q1d1 <= 1'b0; q1d2 <= 1'b0;
      q2d1 <= 1'b0; q2d2 <= 1'b0;
      q3d1 <= 1'b0; q3d2 <= 1'b0;
      fill <= '0;
      dout <= '0;
      dout_vld <= 1'b0;
    end else begin
      dout_vld <= din_vld;
      if (din_vld) begin
        acc1 <= nx1; acc2 <= nx2; acc3 <= nx3;
        q1d1 <= q1; q1d2 <= q1d1;
        q2d1 <= q2; q2d2 <= q2d1;
        q3d1 <= q3; q3d2 <= q3d1;
        fill <= (fill == 2'd2) ? fill : fill + 2'd1;
        dout <= (fill == 2'd2) ? mix : '0;
      end
    end
  end

  p_vld_r2: assert property (@(posedge clk) disable iff (rst)
    din_vld |=> dout_vld);
  p_novld_r2: assert property (@(posedge clk) disable iff (rst)
    !din_vld |=> !dout_vld);
  p_masked_r3: assert property (@(posedge clk) disable iff (rst)
    fill != 2'd2 |-> dout == '0);
  p_odd_r7: assert property (@(posedge clk) disable iff (rst)
    (dout_vld && fill == 2'd2 && $past(fill) == 2'd2) |-> (dout[0] && dout != -OW'(8)));
  p_no_overflow_r8: assert property (@(posedge clk) disable iff (rst)
    (acc1 >= -LIM && acc1 < LIM && acc2 >= -LIM && acc2 < LIM && acc3 >= -LIM && acc3 < LIM));
  p_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !din_vld |=> ($stable(acc1) && $stable(acc2) && $stable(acc3) && $stable(dout)));
endmodule

// File: tb/mash111_mod_test.sv
`timescale 1ns/1ps
module mash111_mod_test;
  localparam int DW = 16;
  localparam longint FS = longint'(1) <<< (DW - 1);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic din_vld = 1'b0;
  logic signed [DW-1:0] din = '0;
  logic dout_vld;
  logic signed [3:0] dout;

  int total = 0;
  int bad = 0;
  int expq[$];
  longint sum_out = 0;
  longint sum_x = 0;
  int out_idx = 0;
  int last_dout = 0;

  longint m1, m2, m3;
  bit h1a, h1b, h2a, h2b, h3a, h3b;
  int mfill;

  always #2.5 clk = ~clk;

  mash111_mod #(.DW(DW)) uut (
    .clk(clk), .rst(rst), .din_vld(din_vld), .din(din),
    .dout_vld(dout_vld), .dout(dout)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int pv(input bit b);
    return b ? 1 : -1;
  endfunction

  task automatic model_clear();
    m1 = 0; m2 = 0; m3 = 0;
    h1a = 0; h1b = 0; h2a = 0; h2b = 0; h3a = 0; h3b = 0;
    mfill = 0;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    din_vld = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    model_clear();
    out_idx = 0; sum_out = 0; sum_x = 0; last_dout = 0;
    @(negedge clk);
    check(dout == 0 && dout_vld == 0, "R1 reset state", dout, 0);
  endtask

  task automatic send(input longint x);
    bit b1, b2, b3;
    longint v1, v2, v3, u2, u3;
    int e;
    b1 = (m1 >= 0); b2 = (m2 >= 0); b3 = (m3 >= 0);
    v1 = b1 ? FS : -FS; v2 = b2 ? FS : -FS; v3 = b3 ? FS : -FS;
    e = pv(h1b) + pv(h2a) - pv(h2b) + pv(b3) - 2 * pv(h3a) + pv(h3b);
    if (mfill < 2) e = 0;
    expq.push_back(e);
    u2 = m1 - v1; u3 = m2 - v2;
    m1 = m1 + x - v1; m2 = m2 + u2 - v2; m3 = m3 + u3 - v3;
    h1b = h1a; h1a = b1; h2b = h2a; h2a = b2; h3b = h3a; h3a = b3;
    mfill++;
    sum_x += x;
    din = DW'(x);
    din_vld = 1'b1;
    @(negedge clk);
  endtask

  task automatic idle(input int n, input bit scramble);
    din_vld = 1'b0;
    for (int i = 0; i < n; i++) begin
      if (scramble) din = DW'(i * 7919 + 12345);
      @(negedge clk);
    end
  endtask

  always @(negedge clk) begin
    if (!rst) begin
      if (dout_vld) begin
        if (expq.size() == 0) begin
          check(0, "R2 unexpected strobe", dout, 0);
        end else begin
          int e;
          e = expq.pop_front();
          check(int'(dout) == e, "R4/R5/R6 code", dout, e);
          if (out_idx < 2)
            check(dout == 0, "R3 masked start", dout, 0);
          else
            check(dout[0] == 1'b1 && dout >= -7, "R7 odd and in range", dout, e);
        end
        sum_out += dout;
        out_idx++;
      end else begin
        check(int'(dout) == last_dout, "R9 output held", dout, last_dout);
      end
      last_dout = dout;
    end
  end

  task automatic run_dc(input longint x, input int n);
    longint diff;
    do_reset();
    for (int i = 0; i < n; i++) send(x);
    idle(4, 0);
    check(expq.size() == 0, "R2 one code per sample", expq.size(), 0);
    diff = sum_out * FS - sum_x;
    if (diff < 0) diff = -diff;
    check(diff <= 16 * FS, "R10 long-run mean", sum_out * FS, sum_x);
  endtask

  initial begin
    #(200000 * 5);
    check(0, "watchdog", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    do_reset();
    run_dc(0, 600);
    run_dc(FS / 2, 600);
    run_dc(-FS / 3, 600);
    run_dc(FS - 1, 800);   // R8 positive extreme
    run_dc(-FS, 800);      // R8 negative extreme
    run_dc(12345, 600);
    do_reset();
    for (int i = 0; i < 1500; i++) begin
      send(((longint'(i) * 1237) % (2 * FS)) - FS);
      if (i % 37 == 5) idle(3, 1);  // R9 gaps with changing din
    end
    idle(4, 1);
    check(expq.size() == 0, "R2 drained after gaps", expq.size(), 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule